// File: doc/BRIEF.md
# Windowed External Memory Access Unit

This unit connects a DSP core's data bus to a word-addressed external memory of 2^20 locations. It offers two routes. In the paged route, a core access made while the core's page register holds the window page (0x3F) goes out to external memory. An index register supplies the upper address byte and the core offset supplies the lower twelve bits. In the streaming route, the core reads or writes one data register. Each access to it goes to a current external address, and that address then moves on by itself. It moves by one word per access in linear mode. In two-dimensional mode it steps by one inside a line and jumps by a programmed stride at the end of each line.

Every external access keeps the strobe asserted for a programmed number of wait cycles. After that count has run out, an external wait pin can stretch the access further. The core sees a one-cycle acknowledge once the strobe ends, together with the captured read data. Software loads the configuration through a separate register write port. Loading the base address sets the streaming address and restarts the line count.

Top module: `xmem_access_unit`

## Requirements
- R1: After reset, mem_en_o, mem_we_o and core_ack_o are low, the wait count is 1, linear mode is selected and the index is 0.
- R2: A core request with core_dreg_i low and core_page_i equal to 0x3F drives mem_addr_o = {index, core_off_i}, with the index in bits 19:12 and the offset in bits 11:0. The address holds for the whole strobe.
- R3: A core request with core_dreg_i low and core_page_i not equal to 0x3F produces no strobe and no acknowledge.
- R4: Register codes on reg_addr_i are: 0 index (bits 7:0), 1 wait count (bits 3:0), 2 mode (bit 0: 0 linear, 1 two-dimensional), 3 base address (bits 19:0), 4 stride (bits 19:0), 5 line length (bits 15:0). A data-register access (core_dreg_i high) uses the current streaming address, which equals the base right after a base write.
- R5: In linear mode, each completed data-register access advances the streaming address by one, modulo 2^20.
- R6: In two-dimensional mode, the address advances by one per access, except after every line-length-th access since the last base write or line end, where the stride is added instead (modulo 2^20). A line length of 0 or 1 adds the stride on every access.
- R7: With the wait pin low, the strobe (mem_en_o) stays high for exactly W cycles, where W is the wait count 1 to 15. A count of 0 acts as 1.
- R8: The wait pin is ignored while the programmed count runs. After the count expires, the access completes in the first cycle the pin is low, so each high cycle adds one strobe cycle.
- R9: core_ack_o is high for exactly the one cycle after the last strobe cycle. In that cycle, core_rdata_o holds mem_rdata_i as sampled on the last strobe cycle.
- R10: For a write, mem_we_o is high and mem_wdata_o equals the core write data for the whole strobe. For a read, mem_we_o stays low.
- R11: A base write in the same cycle as the completion of a data-register access takes priority. The next streaming access uses the new base.
- R12: A paged access does not change the streaming address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Configuration register write strobe |
| reg_addr_i | input | 3 | Configuration register code |
| reg_wdata_i | input | 20 | Configuration write data |
| core_req_i | input | 1 | Core access request, one cycle |
| core_we_i | input | 1 | Core access is a write |
| core_dreg_i | input | 1 | Access targets the streaming data register |
| core_page_i | input | 6 | Core data page register value |
| core_off_i | input | 12 | Core offset within the page |
| core_wdata_i | input | 16 | Core write data |
| core_rdata_o | output | 16 | Read data returned to core |
| core_ack_o | output | 1 | Access complete pulse |
| mem_en_o | output | 1 | External access strobe |
| mem_we_o | output | 1 | External write enable |
| mem_addr_o | output | 20 | External word address |
| mem_wdata_o | output | 16 | External write data |
| mem_rdata_i | input | 16 | External read data |
| mem_wait_i | input | 1 | External wait request |

## Verification
A base-address write and the completion of a streaming access can land on the same clock edge. That edge would both advance the address and overwrite it. The bench times a register write so that it is sampled on the final strobe cycle of a data-register access. It then judges the outcome at the ports: the next streaming access must present the new base, and the one after it must present base plus one.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    RA_INDEX  = 3'd0,
    RA_WAIT   = 3'd1,
    RA_MODE   = 3'd2,
    RA_BASE   = 3'd3,
    RA_STRIDE = 3'd4,
    RA_LINE   = 3'd5
  } reg_addr_e;

  typedef enum logic {
    ST_IDLE,
    ST_ACCESS
  } seq_state_e;
endpackage

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
#(
  parameter int AW    = 20,
  parameter int IDXW  = 8,
  parameter int WAITW = 4,
  parameter int LENW  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [AW-1:0]    wdata_i,
  output logic [IDXW-1:0]  index_o,
  output logic [WAITW-1:0] wait_o,
  output logic             mode2d_o,
  output logic [AW-1:0]    stride_o,
  output logic [LENW-1:0]  line_len_o,
  output logic             base_we_o,
  output logic [AW-1:0]    base_o
);
  reg_addr_e ra;
  assign ra = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_o    <= '0;
      wait_o     <= WAITW'(1);
      mode2d_o   <= 1'b0;
      stride_o   <= AW'(1);
      line_len_o <= LENW'(1);
    end else if (we_i) begin
      case (ra)
        RA_INDEX:  index_o    <= wdata_i[IDXW-1:0];
        RA_WAIT:   wait_o     <= wdata_i[WAITW-1:0];
        RA_MODE:   mode2d_o   <= wdata_i[0];
        RA_STRIDE: stride_o   <= wdata_i;
        RA_LINE:   line_len_o <= wdata_i[LENW-1:0];
        default: ;
      endcase
    end
  end

  assign base_we_o = we_i && (ra == RA_BASE);
  assign base_o    = wdata_i;

  logic unused_bits;
  assign unused_bits = ^wdata_i[AW-1:IDXW];

  // R1
  reset_cfg_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (index_o == '0) && (mode2d_o == 1'b0));
endmodule

// File: rtl/xmem_addr_gen.sv
module xmem_addr_gen #(
  parameter int AW   = 20,
  parameter int LENW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            base_we_i,
  input  logic [AW-1:0]   base_i,
  input  logic            step_i,
  input  logic            mode2d_i,
  input  logic [AW-1:0]   stride_i,
  input  logic [LENW-1:0] line_len_i,
  output logic [AW-1:0]   addr_o
);
  logic [LENW-1:0] line_cnt_q;
  logic [LENW:0]   cnt_nx;
  logic            line_end;

  assign cnt_nx   = {1'b0, line_cnt_q} + 1'b1;
  assign line_end = cnt_nx >= {1'b0, line_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      line_cnt_q <= '0;
    end else if (base_we_i) begin
      // base write outranks a concurrent step
      addr_o     <= base_i;
      line_cnt_q <= '0;
    end else if (step_i) begin
      if (mode2d_i && line_end) begin
        addr_o     <= addr_o + stride_i;
        line_cnt_q <= '0;
      end else begin
        addr_o     <= addr_o + AW'(1);
        line_cnt_q <= mode2d_i ? cnt_nx[LENW-1:0] : '0;
      end
    end
  end

  // R11
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> addr_o == $past(base_i));
  // R5
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mode2d_i && !base_we_i) |=> addr_o == AW'($past(addr_o) + AW'(1)));
  // R12
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !base_we_i) |=> $stable(addr_o));
endmodule

// File: rtl/xmem_wait_seq.sv
module xmem_wait_seq
  import xmem_pkg::*;
#(
  parameter int WAITW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WAITW-1:0] wait_cfg_i,
  input  logic             ext_wait_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ack_o
);
  seq_state_e      state_q;
  logic [WAITW-1:0] cnt_q;

  assign busy_o = (state_q == ST_ACCESS);
  // pin looked at only once the programmed count is used up
  assign done_o = busy_o && (cnt_q == '0) && !ext_wait_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= done_o;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ACCESS;
          cnt_q   <= (wait_cfg_i == '0) ? '0 : wait_cfg_i - 1'b1;
        end
        ST_ACCESS: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (!ext_wait_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> busy_o);
  // R8
  pin_extend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == '0 && ext_wait_i) |=> busy_o);
  // R9
  ack_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ack_o && !busy_o);
  // R9
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/xmem_access_unit.sv
module xmem_access_unit
  import xmem_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int OFFW  = 12,
  parameter int PGW   = 6,
  parameter int WAITW = 4,
  parameter int LENW  = 16,
  parameter logic [PGW-1:0] WIN_PAGE = 6'h3F
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [AW-1:0]   reg_wdata_i,
  input  logic            core_req_i,
  input  logic            core_we_i,
  input  logic            core_dreg_i,
  input  logic [PGW-1:0]  core_page_i,
  input  logic [OFFW-1:0] core_off_i,
  input  logic [DW-1:0]   core_wdata_i,
  output logic [DW-1:0]   core_rdata_o,
  output logic            core_ack_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_wait_i
);
  localparam int IDXW = AW - OFFW;

  logic [IDXW-1:0]  index;
  logic [WAITW-1:0] wait_cfg;
  logic             mode2d, base_we;
  logic [AW-1:0]    stride, base, auto_addr;
  logic [LENW-1:0]  line_len;
  logic             busy, done, accept, win_hit;
  logic             acc_we_q, acc_dreg_q;
  logic [AW-1:0]    acc_addr_q;
  logic [DW-1:0]    acc_wdata_q;

  xmem_regs #(.AW(AW), .IDXW(IDXW), .WAITW(WAITW), .LENW(LENW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .index_o(index), .wait_o(wait_cfg), .mode2d_o(mode2d), .stride_o(stride),
    .line_len_o(line_len), .base_we_o(base_we), .base_o(base)
  );

  xmem_addr_gen #(.AW(AW), .LENW(LENW)) u_agen (
    .clk_i, .rst_ni, .base_we_i(base_we), .base_i(base),
    .step_i(done && acc_dreg_q), .mode2d_i(mode2d), .stride_i(stride),
    .line_len_i(line_len), .addr_o(auto_addr)
  );

  assign win_hit = (core_page_i == WIN_PAGE);
  assign accept  = core_req_i && !busy && (core_dreg_i || win_hit);

  xmem_wait_seq #(.WAITW(WAITW)) u_seq (
    .clk_i, .rst_ni, .start_i(accept), .wait_cfg_i(wait_cfg),
    .ext_wait_i(mem_wait_i), .busy_o(busy), .done_o(done), .ack_o(core_ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_addr_q   <= '0;
      acc_we_q     <= 1'b0;
      acc_dreg_q   <= 1'b0;
      acc_wdata_q  <= '0;
      core_rdata_o <= '0;
    end else begin
      if (accept) begin
        acc_addr_q  <= core_dreg_i ? auto_addr : {index, core_off_i};
        acc_we_q    <= core_we_i;
        acc_dreg_q  <= core_dreg_i;
        acc_wdata_q <= core_wdata_i;
      end
      if (done) core_rdata_o <= mem_rdata_i;
    end
  end

  assign mem_en_o    = busy;
  assign mem_we_o    = busy && acc_we_q;
  assign mem_addr_o  = acc_addr_q;
  assign mem_wdata_o = acc_wdata_q;

  // R10
  we_in_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);
  // R2
  addr_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !done) |=> $stable(mem_addr_o) && $stable(mem_wdata_o));
  // R3
  page_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i && !core_dreg_i && !win_hit && !mem_en_o) |=> !mem_en_o);
endmodule

// File: tb/sim_xmem_access_unit.sv
`timescale 1ns/1ps
module sim_xmem_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic        req = 1'b0, cwe = 1'b0, dreg = 1'b0;
  logic [5:0]  page = '0;
  logic [11:0] off = '0;
  logic [15:0] cwdata = '0;
  logic [15:0] rdata;
  logic        ack, en, mwe, mwait = 1'b0;
  logic [19:0] maddr;
  logic [15:0] mwdata, mrdata;

  int errors = 0;
  int checks = 0;
  int cur_w  = 1;

  always #10 clk = ~clk;
  assign mrdata = maddr[15:0] ^ 16'h5A3C;

  xmem_access_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .core_req_i(req), .core_we_i(cwe), .core_dreg_i(dreg),
    .core_page_i(page), .core_off_i(off), .core_wdata_i(cwdata), .core_rdata_o(rdata),
    .core_ack_o(ack), .mem_en_o(en), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_wait_i(mwait)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd1) cur_w = (d[3:0] == 0) ? 1 : int'(d[3:0]);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // one core access; reports strobe length, first address and the ack cycle values
  task automatic acc(input bit dr, input logic [5:0] pg, input logic [11:0] of,
                     input bit w, input logic [15:0] wd, input int extra,
                     input bit col, input logic [19:0] colv,
                     output int n, output logic [19:0] a, output bit wseen,
                     output logic [15:0] wdseen, output bit ak, output logic [15:0] rd);
    @(negedge clk);
    req = 1'b1; dreg = dr; page = pg; off = of; cwe = w; cwdata = wd;
    @(negedge clk);
    req = 1'b0;
    n = 0; a = '0; wseen = 1'b0; wdseen = '0;
    while (en && n < 64) begin
      n++;
      if (n == 1) begin a = maddr; wdseen = mwdata; end
      if (mwe) wseen = 1'b1;
      mwait = (n <= cur_w - 1 + extra);
      if (col && n == cur_w + extra) begin
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = colv;
      end
      @(negedge clk);
      reg_we = 1'b0;
    end
    mwait = 1'b0;
    ak = ack; rd = rdata;
  endtask

  task automatic sread(input string rq, input logic [19:0] exp);
    int n; logic [19:0] a; bit ws, ak; logic [15:0] wd, rd;
    acc(1'b1, 6'h00, 12'h000, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(a == exp && ak, rq, "stream addr", {12'h0, a}, {12'h0, exp});
  endtask

  // {index, page, offset, hit, expected address}
  localparam logic [46:0] DVEC [6] = '{
    {8'hA5, 6'h3F, 12'h123, 1'b1, 20'hA5123},
    {8'h00, 6'h3F, 12'h000, 1'b1, 20'h00000},
    {8'hFF, 6'h3F, 12'hFFF, 1'b1, 20'hFFFFF},
    {8'h3C, 6'h3E, 12'h456, 1'b0, 20'h00000},
    {8'h01, 6'h00, 12'h800, 1'b0, 20'h00000},
    {8'h80, 6'h3F, 12'h7FF, 1'b1, 20'h807FF}
  };

  initial begin
    int n; logic [19:0] a; bit ws, ak; logic [15:0] wd, rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!en && !mwe && !ack, "R1", "reset outputs", {29'h0, en, mwe, ack}, 32'h0);

    // R1: default wait 1, index 0, linear mode
    acc(1'b0, 6'h3F, 12'h00A, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(n == 1 && a == 20'h0000A, "R1", "default index/wait", {n[11:0], a}, {12'h1, 20'h0000A});

    // R2 / R3: paged window table
    reg_wr(3'd1, 20'd2);
    foreach (DVEC[i]) begin
      reg_wr(3'd0, {12'h0, DVEC[i][46:39]});
      acc(1'b0, DVEC[i][38:33], DVEC[i][32:21], 1'b0, 16'h0, 0, 1'b0, 20'h0,
          n, a, ws, wd, ak, rd);
      if (DVEC[i][20])
        chk(a == DVEC[i][19:0] && n == 2 && ak && rd == (a[15:0] ^ 16'h5A3C),
            "R2", "window addr/rdata", {12'h0, a}, {12'h0, DVEC[i][19:0]});
      else
        chk(n == 0 && !ak, "R3", "page miss no strobe", {n[30:0], ak}, 32'h0);
    end

    // R7: wait counts
    reg_wr(3'd1, 20'd15);
    acc(1'b0, 6'h3F, 12'h001, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(n == 15 && ak, "R7", "wait 15 length", n, 15);
    reg_wr(3'd1, 20'd0);
    acc(1'b0, 6'h3F, 12'h001, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(n == 1 && ak, "R7", "wait 0 acts as 1", n, 1);

    // R8: pin high through count (ignored) plus 3 extra
    reg_wr(3'd1, 20'd4);
    acc(1'b0, 6'h3F, 12'h001, 1'b0, 16'h0, 3, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(n == 7, "R8", "pin extension", n, 7);
    acc(1'b0, 6'h3F, 12'h001, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(n == 4, "R8", "pin ignored during count", n, 4);

    // R9: ack is a single pulse
    @(negedge clk);
    chk(!ack, "R9", "ack one cycle", {31'h0, ack}, 0);

    // R10: write strobes
    reg_wr(3'd1, 20'd3);
    acc(1'b0, 6'h3F, 12'h055, 1'b1, 16'hBEEF, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(ws && wd == 16'hBEEF && n == 3, "R10", "write we/data", {ws, 15'h0, wd}, {1'b1, 15'h0, 16'hBEEF});
    acc(1'b0, 6'h3F, 12'h055, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    chk(!ws, "R10", "read no we", {31'h0, ws}, 0);

    // R4 / R5: linear streaming
    reg_wr(3'd1, 20'd2);
    reg_wr(3'd3, 20'h12340);
    sread("R4", 20'h12340);
    sread("R5", 20'h12341);
    // R12: paged access between streaming accesses
    acc(1'b0, 6'h3F, 12'h999, 1'b0, 16'h0, 0, 1'b0, 20'h0, n, a, ws, wd, ak, rd);
    sread("R12", 20'h12342);
    reg_wr(3'd3, 20'hFFFFF);
    sread("R5", 20'hFFFFF);
    sread("R5", 20'h00000);

    // R6: 2D, len 3, stride 0x10
    reg_wr(3'd2, 20'd1);
    reg_wr(3'd4, 20'h00010);
    reg_wr(3'd5, 20'd3);
    reg_wr(3'd3, 20'h00200);
    sread("R6", 20'h00200);
    sread("R6", 20'h00201);
    sread("R6", 20'h00202);
    sread("R6", 20'h00212);
    sread("R6", 20'h00213);
    sread("R6", 20'h00214);
    sread("R6", 20'h00224);
    // R11: base write mid-line restarts the line
    reg_wr(3'd3, 20'h00300);
    sread("R11", 20'h00300);
    sread("R11", 20'h00301);
    reg_wr(3'd3, 20'h00400);
    sread("R11", 20'h00400);
    sread("R11", 20'h00401);
    sread("R11", 20'h00402);
    sread("R11", 20'h00412);
    // R6: line length 1 and 0
    reg_wr(3'd5, 20'd1);
    reg_wr(3'd4, 20'd5);
    reg_wr(3'd3, 20'h00000);
    sread("R6", 20'h00000);
    sread("R6", 20'h00005);
    reg_wr(3'd5, 20'd0);
    sread("R6", 20'h0000A);
    // R6: 2D wrap
    reg_wr(3'd5, 20'd2);
    reg_wr(3'd4, 20'd4);
    reg_wr(3'd3, 20'hFFFFE);
    sread("R6", 20'hFFFFE);
    sread("R6", 20'hFFFFF);
    sread("R6", 20'h00003);

    // R11: base write on the completing edge of a streaming access
    reg_wr(3'd2, 20'd0);
    reg_wr(3'd3, 20'h05000);
    acc(1'b1, 6'h00, 12'h0, 1'b0, 16'h0, 0, 1'b1, 20'h0A000, n, a, ws, wd, ak, rd);
    chk(a == 20'h05000, "R11", "collision access addr", {12'h0, a}, {12'h0, 20'h05000});
    sread("R11", 20'h0A000);
    sread("R11", 20'h0A001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule